// File: doc/BRIEF.md
# Packed-Pixel Colour Extractor

This block takes one 16-bit memory word that holds several packed pixels and returns the colour of a single chosen pixel. A word can hold sixteen 1-bit pixels, eight 2-bit pixels, four 4-bit pixels, two 8-bit pixels, or one 16-bit pixel. The chosen pixel is right-aligned and zero-extended to the full word width. A flag shows when that colour is zero.

The block sits beside a one-word read cache in a pixel-drawing engine. Two cases occur. When a command hits the cache, the word comes from the cache, and the pixel size, pixel index and colour option come from the command now present. When a read returns from memory later, the command that asked for it has already gone. In that case the word is the one arriving from memory, but the pixel parameters must be the copies stored when the read was issued. A single memory-ready strobe picks both sources, with opposite polarity for the word and for the parameters.

The colour, the zero flag and the colour option are also captured into output registers. These registers load when a read returns, or when a copy command executes on a cache hit. A later paste operation can then use the captured result.

Top module: `pix_unpack`

## Requirements
- R1: The pixel-size code is 4 bits and equals width-1: code 0 means 1 bit, 1 means 2 bits, 3 means 4 bits, 7 means 8 bits and 15 means 16 bits. Any other code is decoded as 1 bit.
- R2: When `mem_ready` is 1, the word that is decoded is `mem_word`. When `mem_ready` is 0, it is `cache_word`.
- R3: When `mem_ready` is 0, the pixel-size code, pixel index and colour option come from the `cmd_*` inputs. When `mem_ready` is 1, they come from the `held_*` inputs.
- R4: Pixels are numbered from the most significant end of the word. For a pixel of width w and lane number k, the colour is bits [15-k*w -: w]. So in 8-bit mode, index 0 gives bits 15:8, and in 1-bit mode, index 0 gives bit 15.
- R5: Only the low log2(16/w) bits of the pixel index are used as the lane number. Higher index bits have no effect.
- R6: The bits of `colour` above the pixel width are always 0.
- R7: `colour_zero` is 1 exactly when `colour` is 0.
- R8: At a clock edge where `mem_ready` or `copy_hit` is 1, the registers load the values of the same cycle: `colour_q` takes `colour`, `colour_zero_q` takes `colour_zero`, and `opt_q` takes the selected colour option.
- R9: At any other clock edge, `colour_q`, `colour_zero_q` and `opt_q` keep their values.
- R10: After a synchronous reset, `colour_q` is 0, `colour_zero_q` is 1 and `opt_q` is 0.
- R11: `colour` and `colour_zero` are combinational. They follow the inputs in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_ready | input | 1 | A memory read word is present this cycle |
| mem_word | input | 16 | Word arriving from memory |
| cache_word | input | 16 | Word held in the one-word cache |
| cmd_bpp | input | 4 | Pixel-size code from the current command |
| cmd_index | input | 4 | Pixel index from the current command |
| cmd_opt | input | 8 | Colour option from the current command |
| held_bpp | input | 4 | Pixel-size code stored when the read was issued |
| held_index | input | 4 | Pixel index stored when the read was issued |
| held_opt | input | 8 | Colour option stored when the read was issued |
| copy_hit | input | 1 | A copy command executes on a cache hit |
| colour | output | 16 | Extracted pixel colour, zero-extended |
| colour_zero | output | 1 | Extracted colour equals zero |
| colour_q | output | 16 | Registered colour |
| colour_zero_q | output | 1 | Registered zero flag |
| opt_q | output | 8 | Registered colour option |

## Verification
The hardest case to create is a late read with crossed sources. The word must come from memory while the pixel parameters come from the stored copies. A design that uses one polarity for both would still look correct whenever the command inputs and the stored inputs are equal.

The stimulus therefore drives the `cmd_*` inputs and the `held_*` inputs with clearly different sizes and indices in the same cycle. It also gives `cache_word` and `mem_word` different values. It then toggles `mem_ready`, so that each of the four source combinations gives a distinct expected colour.

// File: rtl/pix_pkg.sv
package pix_pkg;

    // Which side feeds the decoder on a given cycle
    typedef enum logic {
        SRC_CACHE = 1'b0,
        SRC_MEM   = 1'b1
    } src_e;

    // Maps a size code (width-1) to log2 of the pixel width.
    // Codes that match no supported width fall back to exponent 0 (1-bit pixels).
    function automatic int code_to_exp(input int code, input int top_exp);
        int r;
        r = 0;
        for (int e = 0; e <= top_exp; e++) begin
            if (code == (1 << e) - 1) r = e;
        end
        return r;
    endfunction

endpackage

// File: rtl/pix_src_sel.sv
module pix_src_sel
    import pix_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CODE_W = 4,
    parameter int IDX_W  = 4,
    parameter int OPT_W  = 8
) (
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_word,
    input  logic [WORD_W-1:0] cache_word,
    input  logic [CODE_W-1:0] cmd_bpp,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [OPT_W-1:0]  cmd_opt,
    input  logic [CODE_W-1:0] held_bpp,
    input  logic [IDX_W-1:0]  held_index,
    input  logic [OPT_W-1:0]  held_opt,
    output logic [WORD_W-1:0] sel_word,
    output logic [CODE_W-1:0] sel_bpp,
    output logic [IDX_W-1:0]  sel_index,
    output logic [OPT_W-1:0]  sel_opt
);

    src_e word_src;
    src_e parm_src;

    // The data word and the parameters use opposite strobe polarities.
    // A late read decodes with the parameters stored when it was issued.
    always_comb begin
        word_src = mem_ready ? SRC_MEM : SRC_CACHE;
        parm_src = mem_ready ? SRC_CACHE : SRC_MEM;

        sel_word = (word_src == SRC_MEM) ? mem_word : cache_word;

        if (parm_src == SRC_MEM) begin
            // Strobe low: the command on the inputs is current
            sel_bpp   = cmd_bpp;
            sel_index = cmd_index;
            sel_opt   = cmd_opt;
        end else begin
            sel_bpp   = held_bpp;
            sel_index = held_index;
            sel_opt   = held_opt;
        end
    end

endmodule

// File: rtl/pix_lane_pick.sv
module pix_lane_pick
    import pix_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CODE_W = 4,
    parameter int IDX_W  = 4
) (
    input  logic [WORD_W-1:0] word,
    input  logic [CODE_W-1:0] bpp,
    input  logic [IDX_W-1:0]  index,
    output logic [WORD_W-1:0] colour,
    output logic              colour_zero
);

    localparam int TOP_EXP = $clog2(WORD_W);
    localparam int NEXP    = TOP_EXP + 1;
    localparam int EXP_W   = $clog2(NEXP);

    logic [WORD_W-1:0] cand [NEXP];
    logic [EXP_W-1:0]  exp_sel;

    // One candidate per supported pixel width
    for (genvar g = 0; g < NEXP; g++) begin : g_width
        localparam int W     = 1 << g;
        localparam int LANES = WORD_W / W;
        if (LANES == 1) begin : g_full
            assign cand[g] = word;
        end else begin : g_part
            localparam int LB = TOP_EXP - g;
            logic [LB-1:0] lane;
            logic [W-1:0]  slice;
            // Only the low lane bits of the index matter
            assign lane = index[LB-1:0];
            // Lane 0 is the most significant pixel
            always_comb slice = word[(WORD_W-1) - int'(lane) * W -: W];
            assign cand[g] = {{(WORD_W-W){1'b0}}, slice};
        end
    end

    always_comb begin
        exp_sel     = EXP_W'(code_to_exp(int'(bpp), TOP_EXP));
        colour      = cand[exp_sel];
        colour_zero = (colour == '0);
    end

endmodule

// File: rtl/pix_hold.sv
module pix_hold #(
    parameter int WORD_W = 16,
    parameter int OPT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] colour,
    input  logic              colour_zero,
    input  logic [OPT_W-1:0]  opt,
    output logic [WORD_W-1:0] colour_q,
    output logic              colour_zero_q,
    output logic [OPT_W-1:0]  opt_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            colour_q      <= '0;
            colour_zero_q <= 1'b1;
            opt_q         <= '0;
        end else if (load) begin
            colour_q      <= colour;
            colour_zero_q <= colour_zero;
            opt_q         <= opt;
        end
    end

    // R8: a load edge captures the values of the same cycle
    a_r8_capture: assert property (@(posedge clk) disable iff (rst)
        load |=> (colour_q == $past(colour)) && (opt_q == $past(opt)));

    // R9: no load means the registers keep their values
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(colour_q) && $stable(colour_zero_q) && $stable(opt_q));

    // R7 and R10: the stored flag always matches the stored colour
    a_r7_flag_pair: assert property (@(posedge clk) disable iff (rst)
        colour_zero_q == (colour_q == '0));

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack #(
    parameter int WORD_W = 16,
    parameter int CODE_W = 4,
    parameter int OPT_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       mem_ready,
    input  logic [WORD_W-1:0]          mem_word,
    input  logic [WORD_W-1:0]          cache_word,
    input  logic [CODE_W-1:0]          cmd_bpp,
    input  logic [$clog2(WORD_W)-1:0]  cmd_index,
    input  logic [OPT_W-1:0]           cmd_opt,
    input  logic [CODE_W-1:0]          held_bpp,
    input  logic [$clog2(WORD_W)-1:0]  held_index,
    input  logic [OPT_W-1:0]           held_opt,
    input  logic                       copy_hit,
    output logic [WORD_W-1:0]          colour,
    output logic                       colour_zero,
    output logic [WORD_W-1:0]          colour_q,
    output logic                       colour_zero_q,
    output logic [OPT_W-1:0]           opt_q
);

    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [CODE_W-1:0] CODE_HALF = CODE_W'(WORD_W/2 - 1);
    localparam logic [CODE_W-1:0] CODE_FULL = CODE_W'(WORD_W - 1);

    logic [WORD_W-1:0] sel_word;
    logic [CODE_W-1:0] sel_bpp;
    logic [IDX_W-1:0]  sel_index;
    logic [OPT_W-1:0]  sel_opt;
    logic              load;

    pix_src_sel #(.WORD_W(WORD_W), .CODE_W(CODE_W), .IDX_W(IDX_W), .OPT_W(OPT_W)) u_sel (
        .mem_ready (mem_ready),
        .mem_word  (mem_word),
        .cache_word(cache_word),
        .cmd_bpp   (cmd_bpp),
        .cmd_index (cmd_index),
        .cmd_opt   (cmd_opt),
        .held_bpp  (held_bpp),
        .held_index(held_index),
        .held_opt  (held_opt),
        .sel_word  (sel_word),
        .sel_bpp   (sel_bpp),
        .sel_index (sel_index),
        .sel_opt   (sel_opt)
    );

    pix_lane_pick #(.WORD_W(WORD_W), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_pick (
        .word       (sel_word),
        .bpp        (sel_bpp),
        .index      (sel_index),
        .colour     (colour),
        .colour_zero(colour_zero)
    );

    assign load = mem_ready | copy_hit;

    pix_hold #(.WORD_W(WORD_W), .OPT_W(OPT_W)) u_hold (
        .clk          (clk),
        .rst          (rst),
        .load         (load),
        .colour       (colour),
        .colour_zero  (colour_zero),
        .opt          (sel_opt),
        .colour_q     (colour_q),
        .colour_zero_q(colour_zero_q),
        .opt_q        (opt_q)
    );

    // R2 and R3: a late read in full-width mode returns the memory word unchanged
    a_r2_late_full: assert property (@(posedge clk) disable iff (rst)
        (mem_ready && held_bpp == CODE_FULL) |-> colour == mem_word);

    // R6: in half-width mode the upper half of the colour is zero
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (!mem_ready && cmd_bpp == CODE_HALF) |-> colour[WORD_W-1:WORD_W/2] == '0);

endmodule

// File: tb/sim_pix_unpack.sv
module sim_pix_unpack;

    logic        clk = 1'b0;
    logic        rst;
    logic        mem_ready, copy_hit;
    logic [15:0] mem_word, cache_word;
    logic [3:0]  cmd_bpp, cmd_index, held_bpp, held_index;
    logic [7:0]  cmd_opt, held_opt;
    logic [15:0] colour, colour_q;
    logic        colour_zero, colour_zero_q;
    logic [7:0]  opt_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    pix_unpack u0 (
        .clk(clk), .rst(rst), .mem_ready(mem_ready), .mem_word(mem_word),
        .cache_word(cache_word), .cmd_bpp(cmd_bpp), .cmd_index(cmd_index),
        .cmd_opt(cmd_opt), .held_bpp(held_bpp), .held_index(held_index),
        .held_opt(held_opt), .copy_hit(copy_hit), .colour(colour),
        .colour_zero(colour_zero), .colour_q(colour_q),
        .colour_zero_q(colour_zero_q), .opt_q(opt_q)
    );

    // Reference model: width from code, lane from low index bits, top lane first
    function automatic logic [15:0] ref_pick(logic [15:0] w, logic [3:0] code, logic [3:0] idx);
        int wd, lanes, lane, sh;
        case (code)
            4'd15:   wd = 16;
            4'd7:    wd = 8;
            4'd3:    wd = 4;
            4'd1:    wd = 2;
            default: wd = 1;
        endcase
        lanes = 16 / wd;
        lane  = int'(idx) % lanes;
        sh    = 16 - (lane + 1) * wd;
        return 16'((int'(w) >> sh) & ((1 << wd) - 1));
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle_inputs();
        mem_ready = 0; copy_hit = 0;
        mem_word = 16'h0000; cache_word = 16'h0000;
        cmd_bpp = 0; cmd_index = 0; cmd_opt = 0;
        held_bpp = 0; held_index = 0; held_opt = 0;
    endtask

    task automatic t_reset();
        idle_inputs();
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        #1;
        check("R10 colour_q after reset", colour_q, 0);
        check("R10 colour_zero_q after reset", colour_zero_q, 1);
        check("R10 opt_q after reset", opt_q, 0);
    endtask

    task automatic t_sweep_cache();
        logic [15:0] words [2];
        logic [3:0]  codes [5];
        words[0] = 16'hA5C3; words[1] = 16'h1E0F;
        codes[0] = 0; codes[1] = 1; codes[2] = 3; codes[3] = 7; codes[4] = 15;
        mem_ready = 0;
        mem_word  = 16'hFFFF;
        for (int wi = 0; wi < 2; wi++) begin
            for (int ci = 0; ci < 5; ci++) begin
                for (int ix = 0; ix < 16; ix++) begin
                    cache_word = words[wi];
                    cmd_bpp    = codes[ci];
                    cmd_index  = 4'(ix);
                    held_bpp   = 4'd15;
                    held_index = 4'd0;
                    #1;
                    check("R1 R4 R5 R6 R11 sweep colour", colour,
                          ref_pick(words[wi], codes[ci], 4'(ix)));
                    check("R7 sweep zero flag", colour_zero,
                          ref_pick(words[wi], codes[ci], 4'(ix)) == 0);
                end
            end
        end
    endtask

    task automatic t_order_points();
        mem_ready  = 0;
        cache_word = 16'h8001;
        cmd_bpp = 4'd7; cmd_index = 0; #1;
        check("R4 8bpp index0 is bits 15:8", colour, 16'h0080);
        cmd_index = 1; #1;
        check("R4 8bpp index1 is bits 7:0", colour, 16'h0001);
        cmd_bpp = 4'd0; cmd_index = 0; #1;
        check("R4 1bpp index0 is bit 15", colour, 16'h0001);
        cmd_bpp = 4'd3; cache_word = 16'h1234; cmd_index = 4'd5; #1;
        check("R5 4bpp index5 acts as index1", colour, 16'h0002);
        cmd_bpp = 4'd9; cache_word = 16'h4000; cmd_index = 4'd1; #1;
        check("R1 unknown code decodes as 1bpp", colour, 16'h0001);
    endtask

    task automatic t_crossed_sources();
        cache_word = 16'hABCD;
        mem_word   = 16'h3C5A;
        cmd_bpp  = 4'd3;  cmd_index  = 4'd0;  cmd_opt  = 8'h11;
        held_bpp = 4'd7;  held_index = 4'd1;  held_opt = 8'h22;
        mem_ready = 0; #1;
        check("R2 R3 strobe low uses cache word and command params", colour, 16'h000A);
        mem_ready = 1; #1;
        check("R2 R3 strobe high uses memory word and held params", colour, 16'h005A);
        @(negedge clk);
        check("R8 capture on ready colour", colour_q, 16'h005A);
        check("R8 capture on ready option is held_opt", opt_q, 8'h22);
        check("R8 capture on ready zero flag", colour_zero_q, 0);
    endtask

    task automatic t_hold_and_copy();
        // No load: change everything, registers must hold
        mem_ready = 0; copy_hit = 0;
        cache_word = 16'h0F00; cmd_bpp = 4'd3; cmd_index = 4'd0; cmd_opt = 8'h77;
        #1;
        check("R7 zero flag high when colour zero", colour_zero, 1);
        @(negedge clk);
        check("R9 hold colour_q without load", colour_q, 16'h005A);
        check("R9 hold opt_q without load", opt_q, 8'h22);
        check("R9 hold zero flag without load", colour_zero_q, 0);
        // Copy on cache hit loads a zero colour and the command option
        copy_hit = 1;
        @(negedge clk);
        copy_hit = 0;
        check("R8 copy hit loads colour", colour_q, 16'h0000);
        check("R8 copy hit loads zero flag", colour_zero_q, 1);
        check("R8 copy hit loads command option", opt_q, 8'h77);
        cmd_index = 4'd1; cmd_opt = 8'h01; #1;
        check("R11 colour follows inputs same cycle", colour, 16'h000F);
        @(negedge clk);
        check("R9 hold after copy", opt_q, 8'h77);
    endtask

    initial begin
        rst = 1;
        idle_inputs();
        @(negedge clk);
        t_reset();
        t_sweep_cache();
        t_order_points();
        t_crossed_sources();
        t_hold_and_copy();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule